// File: doc/BRIEF.md
# Output Protection and Fault Controller

This block sits between the latched control bits of a six-channel power output driver and the output stages themselves. It takes per-output switch requests, a software run bit, an open-load detection enable and a delay-select bit. It combines them with digital fault indications and produces the six registered output-stage enables and a 16-bit status word that a serial interface shifts out.

The fault indications are supply under/overvoltage, per-output overcurrent, per-output open-load comparator results, a thermal prewarning and a thermal shutdown. A hardware inhibit pin is also an input. The analog comparators that produce these indications are outside the block; they arrive as synchronous digital levels.

Each fault class has its own recovery rule:
- Supply faults clear by themselves once the supply is back in range, but they leave a sticky flag behind.
- A shorted output stays latched off until a status reset request arrives.
- Thermal shutdown forces the whole status word to ones. Outputs return only after the die has cooled and a reset request has been received.

Delay timers count a slow time-base tick. A one-cycle status reset request clears the sticky state.

Top module: `outstage_guard`

## Requirements
- R1: While reset is asserted, `drive_en` is all zeros and `status` is 16'h0000.
- R2: With no fault and no inhibit, `drive_en[i]` follows `sw_on[i]` one clock later. Status bit i+1 reports output i (i = 0..5). Status bit 0 reports `temp_warn`. Status bits 7..12 read 0.
- R3: If either `run_en` is 0 or `hw_run` is 0, all enables go to 0 and status bit 14 reads 1.
- R4: When `supply_bad` stays high for the selected number of ticks, all enables go to 0 and status bit 15 is set. The count is SUP_SHORT_TICKS with `slow_sel`=0 and SUP_LONG_TICKS with `slow_sel`=1.
- R5: Enables return in the clock after `supply_bad` falls. Status bit 15 stays 1 until a `clr_req` pulse while the supply is good.
- R6: Any timer whose fault condition drops before it expires restarts from zero.
- R7: When `ovc[i]` stays high for the selected short-circuit ticks, only output i is latched off and status bit 13 is set. The count is SC_SHORT_TICKS with `slow_sel`=0 and SC_LONG_TICKS with `slow_sel`=1. The latch persists after `ovc[i]` falls.
- R8: While `temp_warn` is high, an overcurrent on output i latches it off and sets status bit 13 in the next clock, without waiting for ticks.
- R9: A `clr_req` pulse clears status bit 13 and re-enables every latched-off output whose request is still set.
- R10: While `temp_off` is high, and afterwards until a `clr_req` arrives with `temp_off` low, all enables are 0 and `status` reads 16'hFFFF.
- R11: With `ol_en`=1 and `run_en`=1, the status bit of an output whose `sw_on` is 0 reports `open_flag` for that output. An output that is requested on reports its gated enable. With `run_en`=0, open-load flags are ignored.
- R12: `slow_sel`=1 selects the long delay for both supply and short-circuit timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Time-base pulse, one clock wide |
| sw_on | input | 6 | Per-output switch request |
| run_en | input | 1 | Software run bit (0 = inhibit) |
| ol_en | input | 1 | Open-load reporting enable |
| slow_sel | input | 1 | Delay select (1 = long delays) |
| clr_req | input | 1 | Status reset request pulse |
| hw_run | input | 1 | Hardware inhibit pin (0 = inhibit) |
| supply_bad | input | 1 | Supply under/overvoltage indication |
| ovc | input | 6 | Per-output overcurrent flag |
| open_flag | input | 6 | Per-output open-load comparator flag |
| temp_warn | input | 1 | Thermal prewarning |
| temp_off | input | 1 | Thermal shutdown |
| drive_en | output | 6 | Registered output-stage enables |
| status | output | 16 | Registered status word |

## Verification
The enable path is driven with alternating request patterns (000101, 101010). These separate a correct per-output mapping from swapped or shifted bits. Supply and overcurrent faults are held for one tick less than the delay and then for exactly the delay, under both delay selections. This distinguishes an off-by-one count, a missing restart or a swapped delay select. Prewarning combined with overcurrent and no ticks isolates the immediate path. A clear request issued while still hot, followed by one issued after cooling, shows that thermal recovery needs both conditions. Open-load patterns mix on and off outputs under software and hardware inhibit, so reporting of comparator flags can be told apart from reporting of enables.

// File: rtl/og_pkg.sv
package og_pkg;
    localparam int NOUT = 6;
    localparam int SW   = 16;

    // Status word bit positions (decoded by the serial shifter)
    localparam int ST_WARN  = 0;
    localparam int ST_OUT0  = 1;
    localparam int ST_SHORT = 13;
    localparam int ST_INH   = 14;
    localparam int ST_SUPP  = 15;

    typedef struct packed {
        logic [NOUT-1:0] drive;
        logic [NOUT-1:0] latched;
        logic            short_seen;
        logic            supply_seen;
        logic            hot_lock;
        logic [SW-1:0]   status;
    } guard_st_t;
endpackage

// File: rtl/og_tick_timer.sv
module og_tick_timer #(
    parameter int SHORT_TICKS = 3,
    parameter int LONG_TICKS  = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic long_sel,
    output logic expired
);
    localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] END_S = CW'(SHORT_TICKS - 1);
    localparam logic [CW-1:0] END_L = CW'(LONG_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_t;

    tmr_t          r_d, r_q;
    logic [CW-1:0] end_v;

    always_comb begin
        r_d   = r_q;
        end_v = long_sel ? END_L : END_S;
        if (!active) begin
            r_d = '0;
        end else if (tick && !r_q.done) begin
            if (r_q.cnt >= end_v) r_d.done = 1'b1;
            else                  r_d.cnt  = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign expired = r_q.done;
endmodule

// File: rtl/og_status_pack.sv
module og_status_pack
    import og_pkg::*;
(
    input  logic            warn,
    input  logic [NOUT-1:0] out_bits,
    input  logic            short_seen,
    input  logic            inhibited,
    input  logic            supply_seen,
    input  logic            hot_lock,
    output logic [SW-1:0]   word
);
    always_comb begin
        word = '0;
        if (hot_lock) begin
            word = '1;
        end else begin
            word[ST_WARN]                = warn;
            word[ST_OUT0 +: NOUT]        = out_bits;
            word[ST_SHORT]               = short_seen;
            word[ST_INH]                 = inhibited;
            word[ST_SUPP]                = supply_seen;
        end
    end
endmodule

// File: rtl/outstage_guard.sv
module outstage_guard
    import og_pkg::*;
#(
    parameter int SUP_SHORT_TICKS = 3,
    parameter int SUP_LONG_TICKS  = 12,
    parameter int SC_SHORT_TICKS  = 2,
    parameter int SC_LONG_TICKS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [5:0]  sw_on,
    input  logic        run_en,
    input  logic        ol_en,
    input  logic        slow_sel,
    input  logic        clr_req,
    input  logic        hw_run,
    input  logic        supply_bad,
    input  logic [5:0]  ovc,
    input  logic [5:0]  open_flag,
    input  logic        temp_warn,
    input  logic        temp_off,
    output logic [5:0]  drive_en,
    output logic [15:0] status
);
    guard_st_t       st_d, st_q;
    logic            sup_exp;
    logic            sup_off;
    logic            inhibited;
    logic            gate_ok;
    logic [NOUT-1:0] sc_exp;
    logic [NOUT-1:0] sc_active;
    logic [NOUT-1:0] trip;
    logic [NOUT-1:0] ol_act;
    logic [NOUT-1:0] out_bits;
    logic [SW-1:0]   word_d;

    og_tick_timer #(
        .SHORT_TICKS(SUP_SHORT_TICKS),
        .LONG_TICKS (SUP_LONG_TICKS)
    ) u_sup_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .active  (supply_bad),
        .long_sel(slow_sel),
        .expired (sup_exp)
    );

    for (genvar g = 0; g < NOUT; g++) begin : g_sc
        assign sc_active[g] = ovc[g] && !st_q.latched[g];
        og_tick_timer #(
            .SHORT_TICKS(SC_SHORT_TICKS),
            .LONG_TICKS (SC_LONG_TICKS)
        ) u_sc_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .active  (sc_active[g]),
            .long_sel(slow_sel),
            .expired (sc_exp[g])
        );
    end

    og_status_pack u_pack (
        .warn       (temp_warn),
        .out_bits   (out_bits),
        .short_seen (st_d.short_seen),
        .inhibited  (inhibited),
        .supply_seen(st_d.supply_seen),
        .hot_lock   (st_d.hot_lock),
        .word       (word_d)
    );

    always_comb begin
        st_d      = st_q;
        inhibited = !run_en || !hw_run;
        // Supply trip only while the fault is still present: immediate recovery
        sup_off   = sup_exp && supply_bad;
        // Overcurrent trip: after the delay, or at once during prewarning
        trip      = ovc & (sc_exp | {NOUT{temp_warn}}) & ~st_q.latched;

        if (temp_off)     st_d.hot_lock = 1'b1;
        else if (clr_req) st_d.hot_lock = 1'b0;

        if (clr_req) begin
            st_d.latched    = trip;
            st_d.short_seen = |trip;
        end else begin
            st_d.latched    = st_q.latched | trip;
            st_d.short_seen = st_q.short_seen | (|trip);
        end

        if (sup_off)      st_d.supply_seen = 1'b1;
        else if (clr_req) st_d.supply_seen = 1'b0;

        gate_ok    = !inhibited && !sup_off && !st_d.hot_lock;
        st_d.drive = sw_on & ~st_d.latched & {NOUT{gate_ok}};

        ol_act     = {NOUT{ol_en && run_en}} & ~sw_on;
        out_bits   = (ol_act & open_flag) | (~ol_act & st_d.drive);
        st_d.status = word_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign drive_en = st_q.drive;
    assign status   = st_q.status;
endmodule

// File: rtl/og_checker.sv
module og_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  sw_on,
    input logic        run_en,
    input logic        ol_en,
    input logic        hw_run,
    input logic        supply_bad,
    input logic [5:0]  ovc,
    input logic [5:0]  open_flag,
    input logic        temp_off,
    input logic [5:0]  drive_en,
    input logic [15:0] status
);
    // R2: an enable is never granted without its request
    a_r2_drive_subset: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((drive_en & ~$past(sw_on)) == 6'b0));

    // R3: hardware inhibit turns every output off and raises the inhibit bit
    a_r3_pin_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_run |=> (drive_en == 6'b0) && status[14]);

    // R10: thermal shutdown forces all status bits high and outputs off
    a_r10_hot_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        temp_off |=> (status == 16'hFFFF) && (drive_en == 6'b0));

    // R4: the supply-fail bit only rises while the supply is bad
    a_r4_supply_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[15]) && status != 16'hFFFF) |-> $past(supply_bad));

    // R7: the short flag only rises while some output is in overcurrent
    a_r7_short_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[13]) && status != 16'hFFFF) |-> ($past(ovc) != 6'b0));

    // R11: an unrequested output reports its open-load comparator
    a_r11_open_report: assert property (@(posedge clk) disable iff (!rst_n)
        (ol_en && run_en && !sw_on[0] && !temp_off)
        |=> (status[1] == $past(open_flag[0])) || (status == 16'hFFFF));
endmodule

bind outstage_guard og_checker u_og_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_on     (sw_on),
    .run_en    (run_en),
    .ol_en     (ol_en),
    .hw_run    (hw_run),
    .supply_bad(supply_bad),
    .ovc       (ovc),
    .open_flag (open_flag),
    .temp_off  (temp_off),
    .drive_en  (drive_en),
    .status    (status)
);

// File: tb/outstage_guard_bench.sv
module outstage_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [5:0]  sw_on = '0;
    logic        run_en = 1'b0;
    logic        ol_en = 1'b0;
    logic        slow_sel = 1'b0;
    logic        clr_req = 1'b0;
    logic        hw_run = 1'b0;
    logic        supply_bad = 1'b0;
    logic [5:0]  ovc = '0;
    logic [5:0]  open_flag = '0;
    logic        temp_warn = 1'b0;
    logic        temp_off = 1'b0;
    logic [5:0]  drive_en;
    logic [15:0] status;

    always #5 clk = ~clk;

    outstage_guard u_outstage_guard (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sw_on(sw_on), .run_en(run_en),
        .ol_en(ol_en), .slow_sel(slow_sel), .clr_req(clr_req), .hw_run(hw_run),
        .supply_bad(supply_bad), .ovc(ovc), .open_flag(open_flag),
        .temp_warn(temp_warn), .temp_off(temp_off),
        .drive_en(drive_en), .status(status)
    );

    typedef struct {
        string       tag;
        logic [5:0]  drv;
        logic [15:0] st;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    task automatic expect_out(input string tag, input logic [5:0] d, input logic [15:0] s);
        exp_t e;
        e.tag = tag; e.drv = d; e.st = s;
        sbq.push_back(e);
    endtask

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_chk++;
            if (drive_en !== e.drv || status !== e.st) begin
                n_fail++;
                $display("FAIL %s: drive_en=%b status=%h expected drive_en=%b status=%h",
                         e.tag, drive_en, status, e.drv, e.st);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic tk(input int n);
        repeat (n) begin
            tick = 1'b1; @(posedge clk); #1;
            tick = 1'b0; @(posedge clk); #1;
        end
    endtask

    task automatic pulse_clr();
        clr_req = 1'b1; step(1);
        clr_req = 1'b0; step(2);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        step(3);
        expect_out("R1 reset state", 6'b0, 16'h0000);
        step(1);
        rst_n = 1'b1; run_en = 1'b1; hw_run = 1'b1;

        sw_on = 6'b000101; step(2);
        expect_out("R2 pattern 000101", 6'b000101, 16'h000A);
        sw_on = 6'b101010; step(2);
        expect_out("R2 pattern 101010", 6'b101010, 16'h0054);
        temp_warn = 1'b1; step(2);
        expect_out("R2 prewarning bit", 6'b101010, 16'h0055);
        temp_warn = 1'b0;

        hw_run = 1'b0; step(2);
        expect_out("R3 pin inhibit", 6'b0, 16'h4000);
        hw_run = 1'b1; run_en = 1'b0; step(2);
        expect_out("R3 software inhibit", 6'b0, 16'h4000);
        run_en = 1'b1;

        ol_en = 1'b1; sw_on = 6'b000001; open_flag = 6'b000110; step(2);
        expect_out("R11 open-load mix", 6'b000001, 16'h000E);
        run_en = 1'b0; step(2);
        expect_out("R11 soft inhibit masks open-load", 6'b0, 16'h4000);
        run_en = 1'b1; hw_run = 1'b0; step(2);
        expect_out("R11 pin inhibit keeps open-load", 6'b0, 16'h400C);
        hw_run = 1'b1; ol_en = 1'b0; open_flag = 6'b0;

        sw_on = 6'b000011; step(2);
        expect_out("R2 base", 6'b000011, 16'h0006);
        supply_bad = 1'b1; tk(2); step(1);
        expect_out("R4 before supply delay", 6'b000011, 16'h0006);
        tk(1); step(1);
        expect_out("R4 supply trip", 6'b0, 16'h8000);
        supply_bad = 1'b0; step(1);
        expect_out("R5 immediate recovery", 6'b000011, 16'h8006);
        pulse_clr();
        expect_out("R5 sticky flag cleared", 6'b000011, 16'h0006);

        supply_bad = 1'b1; tk(2); supply_bad = 1'b0; step(1);
        supply_bad = 1'b1; tk(2); step(1);
        expect_out("R6 timer restarted", 6'b000011, 16'h0006);
        tk(1); step(1);
        expect_out("R6 trip after full delay", 6'b0, 16'h8000);
        supply_bad = 1'b0; pulse_clr();

        slow_sel = 1'b1; supply_bad = 1'b1; tk(11); step(1);
        expect_out("R12 long supply delay not reached", 6'b000011, 16'h0006);
        tk(1); step(1);
        expect_out("R12 long supply trip", 6'b0, 16'h8000);
        supply_bad = 1'b0; pulse_clr();
        slow_sel = 1'b0;

        ovc = 6'b000001; tk(1); step(1);
        expect_out("R7 before short delay", 6'b000011, 16'h0006);
        tk(1); step(1);
        expect_out("R7 short latch", 6'b000010, 16'h2004);
        ovc = 6'b0; step(2);
        expect_out("R7 latch persists", 6'b000010, 16'h2004);
        pulse_clr();
        expect_out("R9 clear re-enables", 6'b000011, 16'h0006);

        slow_sel = 1'b1; ovc = 6'b000010; tk(15); step(1);
        expect_out("R12 long short delay not reached", 6'b000011, 16'h0006);
        tk(1); step(1);
        expect_out("R12 long short trip", 6'b000001, 16'h2002);
        ovc = 6'b0; pulse_clr(); slow_sel = 1'b0;

        temp_warn = 1'b1; ovc = 6'b000010; step(2);
        expect_out("R8 immediate trip in prewarning", 6'b000001, 16'h2003);
        ovc = 6'b0; temp_warn = 1'b0; pulse_clr();
        expect_out("R9 clear after prewarning trip", 6'b000011, 16'h0006);

        temp_off = 1'b1; step(2);
        expect_out("R10 shutdown", 6'b0, 16'hFFFF);
        pulse_clr();
        expect_out("R10 clear while hot ignored", 6'b0, 16'hFFFF);
        temp_off = 1'b0; step(2);
        expect_out("R10 cooled but not cleared", 6'b0, 16'hFFFF);
        pulse_clr();
        expect_out("R10 cooled and cleared", 6'b000011, 16'h0006);

        step(2);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run not finished, expected completion");
            finish_run();
        end
    end
endmodule